// File: doc/BRIEF.md
# Chunked Free Block Allocator

This block hands out and takes back fixed-size storage blocks for a compressed-memory controller. Storage is divided into equal chunks of blocks. Each chunk keeps a LIFO free list whose links live inside the free blocks. A small on-chip RAM holds one next-pointer per block. The chunks that still have free blocks are kept in a doubly linked chunk list. Every block has the same size, so blocks are never split or merged.

A client issues one request at a time. There are three request kinds. A first-block allocation takes the block at the top of the chunk at the front of the chunk list. An extra-block allocation carries a chunk hint and takes its block from that chunk when the chunk has a free block. Otherwise it falls back to the front chunk. A release pushes a block back onto its own chunk. The block reports completion with a one-cycle done pulse, together with grant or fail and the block number.

After reset the block fills its pointer RAM, one word per cycle, before it accepts requests.

Top module: `fba_alloc`

## Requirements
- R1: After reset, `ready` and `done` are low for exactly NUM_CHUNKS*BLKS_PER_CHUNK cycles while the pointer RAM is filled. Then `ready` goes high.
- R2: Block b belongs to chunk b / BLKS_PER_CHUNK. After reset the chunk list holds the chunks in ascending order. Each chunk hands out its blocks in ascending order.
- R3: A first-block allocation (`req_kind`=2'b00) grants the top block of the chunk at the front of the chunk list. `done` rises two cycles after the accepting edge.
- R4: An extra-block allocation (`req_kind`=2'b01) whose hint chunk has a free block grants the top block of the hint chunk, even when that chunk is not at the front.
- R5: An extra-block allocation whose hint chunk has no free block grants the top block of the front chunk.
- R6: A release (`req_kind[1]`=1) pushes the block onto the top of its chunk's list, so that chunk's next allocation returns it. `done` rises one cycle after the accepting edge, with `grant`=1 and `blk_out` equal to the released block.
- R7: A chunk whose last free block is taken leaves the chunk list. When a block is released into such a chunk, the chunk rejoins at the front of the list.
- R8: When no chunk has a free block, an allocation ends one cycle after the accepting edge with `fail`=1. The free lists are left unchanged.
- R9: `done` is a single-cycle pulse, and `grant` and `fail` are never both set with it. `ready` is low in the cycle between acceptance and the done pulse of a successful allocation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when `ready` is high |
| req_kind | input | 2 | 00 first block, 01 extra block, 1x release |
| req_hint | input | $clog2(NUM_CHUNKS) | Preferred chunk for an extra-block allocation |
| req_blk | input | $clog2(NUM_CHUNKS*BLKS_PER_CHUNK) | Block number to release |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| grant | output | 1 | Request succeeded (valid with `done`) |
| fail | output | 1 | Allocation found no free block (valid with `done`) |
| blk_out | output | $clog2(NUM_CHUNKS*BLKS_PER_CHUNK) | Granted or released block (valid with `done`) |

## Verification
A release or a failed allocation completes one cycle after the accepting clock edge. A successful allocation completes two cycles after it, because it waits one cycle for the next-pointer read from the RAM. The bench drives a request on a falling edge and withdraws it on the next falling edge. It then counts falling edges until `done`, compares that count with the latency due for the request kind, and checks that `ready` is low at the intermediate edge of a successful allocation. A queue model of the chunk list and per-chunk stacks predicts each granted block at the moment the pulse is sampled.

// File: rtl/fba_pkg.sv
package fba_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_POP  = 2'd2
  } fba_state_t;
endpackage

// File: rtl/fba_link_ram.sv
module fba_link_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 7,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fba_chunk_dir.sv
// Per-chunk head pointers plus the doubly linked list of non-empty chunks.
module fba_chunk_dir #(
  parameter int NUM_CHUNKS     = 4,
  parameter int BLKS_PER_CHUNK = 16,
  localparam int NB = NUM_CHUNKS * BLKS_PER_CHUNK,
  localparam int BW = $clog2(NB),
  localparam int CW = $clog2(NUM_CHUNKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_en,
  input  logic [CW-1:0]         set_c,
  input  logic [BW-1:0]         set_blk,
  input  logic                  set_ok,
  input  logic [CW-1:0]         q_c,
  output logic [BW-1:0]         q_blk,
  output logic [NUM_CHUNKS-1:0] ok_vec,
  output logic [CW-1:0]         front_c,
  output logic                  front_ok
);
  logic [BW-1:0] hblk [NUM_CHUNKS];
  logic          hok  [NUM_CHUNKS];
  logic [CW-1:0] nx   [NUM_CHUNKS];
  logic          nxok [NUM_CHUNKS];
  logic [CW-1:0] pv   [NUM_CHUNKS];
  logic          pvok [NUM_CHUNKS];
  logic [CW-1:0] lhead;
  logic          lhok;

  always_comb begin
    for (int c = 0; c < NUM_CHUNKS; c++) ok_vec[c] = hok[c];
  end
  assign q_blk    = hblk[q_c];
  assign front_c  = lhead;
  assign front_ok = lhok;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CHUNKS; c++) begin
        hblk[c] <= BW'(c * BLKS_PER_CHUNK);
        hok[c]  <= 1'b1;
        nx[c]   <= CW'(c + 1);
        nxok[c] <= (c < NUM_CHUNKS - 1);
        pv[c]   <= CW'(c - 1);
        pvok[c] <= (c > 0);
      end
      lhead <= '0;
      lhok  <= 1'b1;
    end else if (set_en) begin
      hblk[set_c] <= set_blk;
      hok[set_c]  <= set_ok;
      if (set_ok && !hok[set_c]) begin
        // chunk regains a free block: insert at the front
        nx[set_c]   <= lhead;
        nxok[set_c] <= lhok;
        pvok[set_c] <= 1'b0;
        if (lhok) begin
          pv[lhead]   <= set_c;
          pvok[lhead] <= 1'b1;
        end
        lhead <= set_c;
        lhok  <= 1'b1;
      end else if (!set_ok && hok[set_c]) begin
        // chunk ran dry: unlink it
        if (pvok[set_c]) begin
          nx[pv[set_c]]   <= nx[set_c];
          nxok[pv[set_c]] <= nxok[set_c];
        end else begin
          lhead <= nx[set_c];
          lhok  <= nxok[set_c];
        end
        if (nxok[set_c]) begin
          pv[nx[set_c]]   <= pv[set_c];
          pvok[nx[set_c]] <= pvok[set_c];
        end
      end
    end
  end
endmodule

// File: rtl/fba_alloc.sv
module fba_alloc
  import fba_pkg::*;
#(
  parameter int NUM_CHUNKS     = 4,
  parameter int BLKS_PER_CHUNK = 16,
  localparam int NB = NUM_CHUNKS * BLKS_PER_CHUNK,
  localparam int BW = $clog2(NB),
  localparam int CW = $clog2(NUM_CHUNKS),
  localparam int LB = $clog2(BLKS_PER_CHUNK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [CW-1:0] req_hint,
  input  logic [BW-1:0] req_blk,
  output logic          ready,
  output logic          done,
  output logic          grant,
  output logic          fail,
  output logic [BW-1:0] blk_out
);
  fba_state_t st;
  logic [BW-1:0] init_i;
  logic [CW-1:0] sel_c;
  logic [BW-1:0] sel_b;

  logic [NUM_CHUNKS-1:0] ok_vec;
  logic [CW-1:0] front_c, q_c, pick_c, rel_c, set_c;
  logic          front_ok, set_en, set_ok;
  logic [BW-1:0] q_blk, set_blk;
  logic          is_rel, is_ext, use_hint, avail, acc;
  logic          ram_we;
  logic [BW-1:0] ram_wa;
  logic [BW:0]   ram_wd, ram_rd;

  assign is_rel   = req_kind[1];
  assign is_ext   = ~req_kind[1] & req_kind[0];
  assign rel_c    = req_blk[BW-1:LB];
  assign use_hint = is_ext && ok_vec[req_hint];
  assign pick_c   = use_hint ? req_hint : front_c;
  assign avail    = use_hint || front_ok;
  assign q_c      = is_rel ? rel_c : pick_c;
  assign ready    = (st == ST_IDLE);
  assign acc      = req_valid && ready;

  always_comb begin
    ram_we = 1'b0;
    ram_wa = req_blk;
    ram_wd = {~ok_vec[rel_c], q_blk};
    if (st == ST_INIT) begin
      ram_we = 1'b1;
      ram_wa = init_i;
      ram_wd = {&init_i[LB-1:0], init_i + BW'(1)};
    end else if (acc && is_rel) begin
      ram_we = 1'b1;
    end
  end

  always_comb begin
    set_en  = 1'b0;
    set_c   = rel_c;
    set_blk = req_blk;
    set_ok  = 1'b1;
    if (st == ST_POP) begin
      set_en  = 1'b1;
      set_c   = sel_c;
      set_blk = ram_rd[BW-1:0];
      set_ok  = ~ram_rd[BW];
    end else if (acc && is_rel) begin
      set_en = 1'b1;
    end
  end

  fba_link_ram #(.DEPTH(NB), .WIDTH(BW + 1)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
    .raddr(q_blk), .rdata(ram_rd)
  );

  fba_chunk_dir #(.NUM_CHUNKS(NUM_CHUNKS), .BLKS_PER_CHUNK(BLKS_PER_CHUNK)) u_dir (
    .clk(clk), .rst(rst), .set_en(set_en), .set_c(set_c), .set_blk(set_blk),
    .set_ok(set_ok), .q_c(q_c), .q_blk(q_blk), .ok_vec(ok_vec),
    .front_c(front_c), .front_ok(front_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_INIT;
      init_i  <= '0;
      sel_c   <= '0;
      sel_b   <= '0;
      done    <= 1'b0;
      grant   <= 1'b0;
      fail    <= 1'b0;
      blk_out <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_INIT: begin
          init_i <= init_i + BW'(1);
          if (init_i == BW'(NB - 1)) st <= ST_IDLE;
        end
        ST_IDLE: if (acc) begin
          if (is_rel) begin
            done    <= 1'b1;
            grant   <= 1'b1;
            fail    <= 1'b0;
            blk_out <= req_blk;
          end else if (!avail) begin
            done  <= 1'b1;
            grant <= 1'b0;
            fail  <= 1'b1;
          end else begin
            sel_c <= pick_c;
            sel_b <= q_blk;
            st    <= ST_POP;
          end
        end
        ST_POP: begin
          done    <= 1'b1;
          grant   <= 1'b1;
          fail    <= 1'b0;
          blk_out <= sel_b;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fba_alloc_chk.sv
module fba_alloc_chk #(
  parameter int NUM_CHUNKS     = 4,
  parameter int BLKS_PER_CHUNK = 16,
  localparam int NB = NUM_CHUNKS * BLKS_PER_CHUNK,
  localparam int BW = $clog2(NB),
  localparam int CW = $clog2(NUM_CHUNKS),
  localparam int LB = $clog2(BLKS_PER_CHUNK)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [1:0]            req_kind,
  input logic [CW-1:0]         req_hint,
  input logic [BW-1:0]         req_blk,
  input logic                  ready,
  input logic                  done,
  input logic                  grant,
  input logic                  fail,
  input logic [BW-1:0]         blk_out,
  input logic [NUM_CHUNKS-1:0] ok_vec
);
  p_init_quiet_r1: assert property (@(posedge clk) rst |=> (!ready && !done));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (grant != fail));

  p_alloc_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && !req_kind[1]) |=> ((done && fail) || (!ready && !done)));

  p_release_echo_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && req_kind[1]) |=> (done && grant && blk_out == $past(req_blk)));

  p_hint_chunk_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && req_kind == 2'b01 && ok_vec[req_hint])
      |=> ##1 (done && grant && blk_out[BW-1:LB] == $past(req_hint, 2)));

  p_empty_fail_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && !req_kind[1] && ok_vec == '0) |=> (done && fail));
endmodule

bind fba_alloc fba_alloc_chk #(.NUM_CHUNKS(NUM_CHUNKS), .BLKS_PER_CHUNK(BLKS_PER_CHUNK)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .req_hint(req_hint), .req_blk(req_blk), .ready(ready), .done(done),
  .grant(grant), .fail(fail), .blk_out(blk_out), .ok_vec(ok_vec)
);

// File: tb/tb_fba_alloc.sv
module tb_fba_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NC  = 4;
  localparam int BPC = 16;
  localparam int NB  = NC * BPC;
  localparam int BW  = $clog2(NB);
  localparam int CW  = $clog2(NC);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = 2'b00;
  logic [CW-1:0] req_hint = '0;
  logic [BW-1:0] req_blk = '0;
  logic          ready, done, grant, fail;
  logic [BW-1:0] blk_out;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fba_alloc #(.NUM_CHUNKS(NC), .BLKS_PER_CHUNK(BPC)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_hint(req_hint), .req_blk(req_blk), .ready(ready), .done(done),
    .grant(grant), .fail(fail), .blk_out(blk_out)
  );

  int total = 0;
  int bad   = 0;

  // reference model: per-chunk stacks (top = last) and chunk order list
  int stk [NC][BPC];
  int sp  [NC];
  int order [$];
  int owned [$];

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_init();
    order = {};
    for (int c = 0; c < NC; c++) begin
      for (int k = 0; k < BPC; k++) stk[c][k] = c * BPC + (BPC - 1 - k);
      sp[c] = BPC;
      order.push_back(c);
    end
  endtask

  task automatic model_alloc(input int kind, input int hint, output bit mf,
                             output int mb, output string tag);
    int c;
    mb = 0;
    if (kind == 1 && sp[hint] > 0) begin
      c = hint; tag = "R4";
    end else if (order.size() == 0) begin
      mf = 1; tag = "R8"; return;
    end else begin
      c = order[0]; tag = (kind == 1) ? "R5" : "R3";
    end
    mf = 0;
    sp[c]--;
    mb = stk[c][sp[c]];
    if (sp[c] == 0) begin
      for (int i = 0; i < order.size(); i++)
        if (order[i] == c) begin order.delete(i); break; end
    end
  endtask

  task automatic model_release(input int b);
    int c = b / BPC;
    if (sp[c] == 0) order.push_front(c);
    stk[c][sp[c]] = b;
    sp[c]++;
  endtask

  // drive one request, return outcome and latency in cycles after acceptance
  task automatic issue(input int kind, input int hint, input int blk,
                       output bit g, output bit f, output int ob,
                       output int lat, output bit mid_ready);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'(kind);
    req_hint  = CW'(hint);
    req_blk   = BW'(blk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    mid_ready = ready;
    while (!done && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    g = grant; f = fail; ob = int'(blk_out);
  endtask

  task automatic do_alloc(input int kind, input int hint);
    bit mf, g, f, mr;
    int mb, ob, lat;
    string tag;
    model_alloc(kind, hint, mf, mb, tag);
    issue(kind, hint, 0, g, f, ob, lat, mr);
    check_eq(tag, "fail", int'(f), int'(mf));
    check_eq(tag, "grant", int'(g), int'(!mf));
    if (mf) begin
      check_eq("R8", "latency", lat, 1);
    end else begin
      check_eq(tag, "block", ob, mb);
      check_eq("R9", "latency", lat, 2);
      check_eq("R9", "ready_mid", int'(mr), 0);
      if (!f) owned.push_back(ob);
    end
  endtask

  task automatic do_release(input int idx);
    bit g, f, mr;
    int ob, lat;
    int b = owned[idx];
    owned.delete(idx);
    model_release(b);
    issue(2, 0, b, g, f, ob, lat, mr);
    check_eq("R6", "grant", int'(g), 1);
    check_eq("R6", "echo", ob, b);
    check_eq("R6", "latency", lat, 1);
  endtask

  task automatic release_block(input int b);
    for (int i = 0; i < owned.size(); i++)
      if (owned[i] == b) begin do_release(i); return; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd4242));
    model_init();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cnt = 0;
    check_eq("R1", "ready_after_reset", int'(ready), 0);
    check_eq("R1", "done_after_reset", int'(done), 0);
    while (!ready && cnt < 4 * NB) begin
      @(negedge clk);
      cnt++;
    end
    check_eq("R1", "init_cycles", cnt, NB);

    // R2/R3: ascending hand-out from chunk 0
    do_alloc(0, 0);
    do_alloc(0, 0);
    do_alloc(0, 0);
    // R4: hint picks a chunk not at the front
    do_alloc(1, 2);
    // R6: LIFO return
    release_block(1);
    do_alloc(0, 0);
    // drain chunk 3 through hints, then R5 fallback
    for (int i = 0; i < BPC; i++) do_alloc(1, 3);
    do_alloc(1, 3);
    // R7/R8: exhaust everything, then fail twice
    while (order.size() > 0) do_alloc(0, 0);
    do_alloc(0, 0);
    do_alloc(1, 1);
    // R7: empty chunk rejoins at the front after a release
    release_block(50);
    release_block(20);
    do_alloc(0, 0);
    do_alloc(0, 0);
    do_alloc(1, 3);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int r = int'($urandom % 5);
      if (r < 2 && owned.size() > 0)
        do_release(int'($urandom % owned.size()));
      else
        do_alloc(int'($urandom % 2), int'($urandom % NC));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule